// File: doc/BRIEF.md
# Handshaked Euclidean GCD Unit

This block finds the greatest common divisor of two unsigned integers by repeated subtraction and exchange. A control state machine steers a small datapath of two operand registers. Each cycle of work does one of two things. If the first register is smaller than the second, the two values are exchanged. Otherwise, if the second register is non-zero, the second is subtracted from the first. Work stops when the first register is not smaller and the second is zero. The first register then holds the answer.

Operands arrive on a valid/ready input stream and the answer leaves on a separate valid/ready output stream. A transfer happens only on a rising clock edge where both valid and ready are high. The unit accepts one operand pair, works on it alone and presents the answer. It takes no new pair until the consumer has taken that answer. The producer may hold valid high for as long as it likes. The consumer may hold ready low for as long as it likes, and the answer waits unchanged. The operand width is set by the parameter `WIDTH`.

Top module: `gcd_unit`

## Requirements
- R1: While `rst` is high at a clock edge, and in the cycle after it, `opnd_ready` is 1 and `res_valid` is 0, even if a computation was in progress.
- R2: `opnd_ready` is 1 only while the unit is idle. The edge on which `opnd_valid` and `opnd_ready` are both high loads the operands, and `opnd_ready` is 0 in the following cycle.
- R3: For two non-zero operands, `res_value` equals their greatest common divisor when `res_valid` is 1. For example, 32 and 48 give 16.
- R4: If both operands are zero, the result is 0. If exactly one operand is zero, the result is the other operand.
- R5: While `res_valid` is 1 and `res_ready` is 0, `res_valid` stays 1 and `res_value` does not change at the next edge.
- R6: The edge on which `res_valid` and `res_ready` are both high ends the transfer. In the next cycle `res_valid` is 0 and `opnd_ready` is 1.
- R7: Changes on `opnd_a`, `opnd_b` and `opnd_valid` while the unit is busy have no effect on the result that follows.
- R8: `opnd_ready` and `res_valid` are never 1 in the same cycle. While the unit is idle and `opnd_valid` is 0, `res_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opnd_valid | input | 1 | Operand pair offered |
| opnd_ready | output | 1 | Unit idle and able to take an operand pair |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| res_valid | output | 1 | Result offered |
| res_ready | input | 1 | Consumer takes the result |
| res_value | output | WIDTH | Greatest common divisor |

## Verification
The bench feeds zero operands. A unit that tested only for the smaller value would either stall with a zero divisor or subtract forever, and the 0/0, 0/n and n/0 cases would time out or return the wrong value. It holds the result back for several cycles. A unit that kept iterating or dropped valid in that state would change the offered value. It also changes the operand inputs while the unit is busy, which exposes a unit that reloads outside the idle state. Finally it applies reset in the middle of a computation and a long subtraction chain (1000 and 1).

// File: rtl/gcd_pkg.sv
package gcd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } state_e;

  typedef enum logic [1:0] {
    ASEL_IN   = 2'd0,
    ASEL_B    = 2'd1,
    ASEL_DIFF = 2'd2
  } a_sel_e;

  typedef enum logic {
    BSEL_IN = 1'b0,
    BSEL_A  = 1'b1
  } b_sel_e;
endpackage

// File: rtl/gcd_datapath.sv
module gcd_datapath
  import gcd_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             a_en,
  input  logic             b_en,
  input  a_sel_e           a_sel,
  input  b_sel_e           b_sel,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic             a_lt_b,
  output logic             b_zero,
  output logic [WIDTH-1:0] value
);
  logic [WIDTH-1:0] a_q, b_q, a_d, b_d, diff;

  assign diff   = a_q - b_q;
  assign a_lt_b = (a_q < b_q);
  assign b_zero = (b_q == '0);
  assign value  = a_q;

  always_comb begin
    case (a_sel)
      ASEL_B:    a_d = b_q;
      ASEL_DIFF: a_d = diff;
      default:   a_d = in_a;
    endcase
  end

  always_comb begin
    case (b_sel)
      BSEL_A:  b_d = a_q;
      default: b_d = in_b;
    endcase
  end

  always_ff @(posedge clk) begin
    if (a_en) a_q <= a_d;
    if (b_en) b_q <= b_d;
  end
endmodule

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
  import gcd_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   opnd_valid,
  input  logic   res_ready,
  input  logic   a_lt_b,
  input  logic   b_zero,
  output logic   opnd_ready,
  output logic   res_valid,
  output logic   a_en,
  output logic   b_en,
  output a_sel_e a_sel,
  output b_sel_e b_sel
);
  state_e state_q, state_d;

  assign opnd_ready = (state_q == ST_IDLE);
  assign res_valid  = (state_q == ST_HOLD);

  always_comb begin
    state_d = state_q;
    a_en    = 1'b0;
    b_en    = 1'b0;
    a_sel   = ASEL_IN;
    b_sel   = BSEL_IN;
    case (state_q)
      ST_IDLE: begin
        if (opnd_valid) begin
          a_en    = 1'b1;
          b_en    = 1'b1;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (a_lt_b) begin
          a_en  = 1'b1;
          b_en  = 1'b1;
          a_sel = ASEL_B;
          b_sel = BSEL_A;
        end else if (!b_zero) begin
          a_en  = 1'b1;
          a_sel = ASEL_DIFF;
        end else begin
          state_d = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (res_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/gcd_unit.sv
module gcd_unit
  import gcd_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             opnd_valid,
  output logic             opnd_ready,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [WIDTH-1:0] res_value
);
  logic   a_en, b_en, a_lt_b, b_zero;
  a_sel_e a_sel;
  b_sel_e b_sel;

  gcd_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .opnd_valid (opnd_valid),
    .res_ready  (res_ready),
    .a_lt_b     (a_lt_b),
    .b_zero     (b_zero),
    .opnd_ready (opnd_ready),
    .res_valid  (res_valid),
    .a_en       (a_en),
    .b_en       (b_en),
    .a_sel      (a_sel),
    .b_sel      (b_sel)
  );

  gcd_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .a_en   (a_en),
    .b_en   (b_en),
    .a_sel  (a_sel),
    .b_sel  (b_sel),
    .in_a   (opnd_a),
    .in_b   (opnd_b),
    .a_lt_b (a_lt_b),
    .b_zero (b_zero),
    .value  (res_value)
  );
endmodule

// File: rtl/gcd_unit_chk.sv
module gcd_unit_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             opnd_valid,
  input logic             opnd_ready,
  input logic             res_valid,
  input logic             res_ready,
  input logic [WIDTH-1:0] res_value
);
  // R1: reset returns both stream sides to idle
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (opnd_ready && !res_valid));

  // R2: an accepted pair makes the unit busy
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (opnd_valid && opnd_ready) |=> !opnd_ready);

  // R5: an offered result is held under back-pressure
  p_hold_result_r5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_value)));

  // R6: a taken result frees the unit
  p_release_r6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_ready) |=> (!res_valid && opnd_ready));

  // R8: input and output sides never open together
  p_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    !(opnd_ready && res_valid));

  // R8: an idle unit with no offer produces nothing
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (opnd_ready && !opnd_valid) |=> !res_valid);
endmodule

bind gcd_unit gcd_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .opnd_valid (opnd_valid),
  .opnd_ready (opnd_ready),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_value  (res_value)
);

// File: tb/test_gcd_unit.sv
module test_gcd_unit;
  localparam int W  = 16;
  localparam int NV = 11;

  // each entry: {a, b, expected gcd}
  localparam logic [3*W-1:0] VECS [NV] = '{
    {16'd32,    16'd48,    16'd16},
    {16'd48,    16'd32,    16'd16},
    {16'd7,     16'd13,    16'd1},
    {16'd21,    16'd14,    16'd7},
    {16'd100,   16'd75,    16'd25},
    {16'd65535, 16'd65535, 16'd65535},
    {16'd1000,  16'd1,     16'd1},
    {16'd0,     16'd0,     16'd0},
    {16'd0,     16'd9,     16'd9},
    {16'd9,     16'd0,     16'd9},
    {16'd65535, 16'd0,     16'd65535}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         opnd_valid = 1'b0;
  logic         opnd_ready;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic         res_valid;
  logic         res_ready = 1'b0;
  logic [W-1:0] res_value;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;

  gcd_unit #(.WIDTH(W)) i_gcd_unit (
    .clk        (clk),
    .rst        (rst),
    .opnd_valid (opnd_valid),
    .opnd_ready (opnd_ready),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .res_valid  (res_valid),
    .res_ready  (res_ready),
    .res_value  (res_value)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one full transaction; hold = cycles of back-pressure, noisy = disturb inputs
  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b,
                     input logic [W-1:0] exp, input int hold, input bit noisy,
                     input string tag);
    logic [W-1:0] first;
    int waited;
    opnd_valid = 1'b1;
    opnd_a = a;
    opnd_b = b;
    tick();
    check("R2 busy after accept", int'(opnd_ready), 0);
    if (noisy) begin
      opnd_a = ~a;
      opnd_b = b + 16'd3;
      opnd_valid = 1'b1;
    end else begin
      opnd_valid = 1'b0;
    end
    waited = 0;
    while (!res_valid && waited < 5000) begin
      tick();
      waited++;
    end
    opnd_valid = 1'b0;
    check({tag, " result"}, int'(res_value), int'(exp));
    check("R8 exclusive", int'(opnd_ready && res_valid), 0);
    first = res_value;
    for (int i = 0; i < hold; i++) begin
      tick();
      check("R5 valid held", int'(res_valid), 1);
      check("R5 value held", int'(res_value), int'(first));
    end
    res_ready = 1'b1;
    tick();
    res_ready = 1'b0;
    check("R6 valid drops", int'(res_valid), 0);
    check("R6 ready returns", int'(opnd_ready), 1);
  endtask

  initial begin
    repeat (3) tick();
    check("R1 ready in reset", int'(opnd_ready), 1);
    check("R1 no result in reset", int'(res_valid), 0);
    rst = 1'b0;
    tick();
    check("R1 ready after reset", int'(opnd_ready), 1);

    // R8: idle with no offer stays quiet
    for (int i = 0; i < 6; i++) begin
      tick();
      check("R8 idle quiet", int'(res_valid), 0);
    end

    for (int k = 0; k < NV; k++) begin
      // R3 for non-zero pairs, R4 for pairs with a zero
      run(VECS[k][3*W-1:2*W], VECS[k][2*W-1:W], VECS[k][W-1:0], k % 3, 1'b0,
          (VECS[k][3*W-1:2*W] == 0 || VECS[k][2*W-1:W] == 0) ? "R4" : "R3");
    end

    // R7: inputs disturbed while busy
    run(16'd84, 16'd36, 16'd12, 0, 1'b1, "R7");
    run(16'd5, 16'd0, 16'd5, 2, 1'b1, "R7 zero");

    // R5: long back-pressure
    run(16'd270, 16'd192, 16'd6, 8, 1'b0, "R5 long hold");

    // R1: reset in the middle of a long computation
    opnd_valid = 1'b1;
    opnd_a = 16'd1000;
    opnd_b = 16'd1;
    tick();
    opnd_valid = 1'b0;
    repeat (20) tick();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    check("R1 ready after mid reset", int'(opnd_ready), 1);
    check("R1 no result after mid reset", int'(res_valid), 0);
    run(16'd18, 16'd12, 16'd6, 1, 1'b0, "R1 after mid reset");

    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule